// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a small first-in first-out byte buffer. It sits between the bus-side engine that fetches instruction words and the decoder that consumes instruction bytes. On each accepted fetch, the write side takes a 16-bit word that holds up to two instruction bytes. The read side hands out one byte per cycle from the head of the queue. The current fill level drives a fetch-request output, so the fetch engine starts a new bus cycle only when a whole word is sure to fit.

A taken jump or call means the bytes already fetched are useless. A flush input drops all of them at once, and refilling then starts from the new target. Some fetches start at an odd target address. For those, a two-bit byte-enable on the write port lets the fetch side push only the upper byte of the word.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue holds no bytes: `level_o` is 0, `rd_valid_o` is 0 and `fetch_req_o` is 1.
- R2: Bytes leave in the order they were accepted. Within one word, bits 7:0 are accepted before bits 15:8.
- R3: `rd_valid_o` is 1 exactly when at least one byte is held, and `rd_data_o` then shows the oldest byte. A pop (`rd_en_i` high while `rd_valid_o` is high) removes one byte at the clock edge. A pop request while the queue is empty has no effect.
- R4: The queue holds at most 6 bytes. A write is accepted only if the free slots before the edge, not counting a pop in the same cycle, are at least the number of enabled bytes. A write that is not accepted stores nothing.
- R5: `fetch_req_o` is 1 exactly when at least two byte slots are free, that is when `level_o` is 4 or less.
- R6: `wr_mask_i` bit 0 enables the low byte (bits 7:0) and bit 1 enables the high byte (bits 15:8). With mask 2'b10 only the high byte is stored. With 2'b01 only the low byte is stored. With 2'b00 nothing is stored.
- R7: `flush_i` takes priority over any write or pop in the same cycle. On the following cycle `level_o` is 0 and `rd_valid_o` is 0, and bytes written afterwards come out first.
- R8: When a write and a pop are both accepted in one cycle, the level changes by the number of bytes written minus one. No byte is lost or duplicated.
- R9: `level_o` always equals the number of bytes held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard every held byte |
| wr_en_i | input | 1 | Write request for one fetched word |
| wr_data_i | input | 16 | Fetched word; low byte comes first |
| wr_mask_i | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| rd_en_i | input | 1 | Pop one byte from the head |
| rd_data_o | output | 8 | Oldest held byte |
| rd_valid_o | output | 1 | Queue is not empty |
| level_o | output | 3 | Number of held bytes |
| fetch_req_o | output | 1 | At least two slots are free |

## Verification
The bench goes after the storage wrap-around. There, a two-byte write splits across the last and first slots, and a design with wrong modulo arithmetic would return stale or swapped bytes. It also drives a write plus a pop at levels 5 and 6. A design that counted the pop as freeing space would accept a word it cannot hold, and one that mishandled the net change would drift its level. Flushes land together with writes and pops, where a design that let either through would show a nonzero level or an old byte after the flush. Single-byte masks and pops on an empty queue check that order and level hold where a careless design would push the wrong half or underflow.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef logic [7:0] byte_t;

  function automatic logic [1:0] mask_bytes(input logic [1:0] m);
    return {1'b0, m[0]} + {1'b0, m[1]};
  endfunction
endpackage

// File: rtl/pq_ptr_adv.sv
module pq_ptr_adv #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [PW-1:0] ptr_i,
  input  logic [1:0]    inc_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW:0] sum;

  always_comb begin
    sum = {1'b0, ptr_i} + (PW+1)'(inc_i);
    if (sum >= (PW+1)'(DEPTH)) sum = sum - (PW+1)'(DEPTH);
    ptr_o = sum[PW-1:0];
  end
endmodule

// File: rtl/pq_level.sv
module pq_level #(
  parameter int DEPTH = 6,
  localparam int LW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [1:0]    add_i,
  input  logic          sub_i,
  output logic [LW-1:0] level_o
);
  logic [LW-1:0] level_q, level_d;

  always_comb begin
    if (flush_i) level_d = '0;
    else         level_d = level_q + LW'(add_i) - LW'(sub_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/pq_store.sv
module pq_store #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_a_i,
  input  logic [PW-1:0] addr_a_i,
  input  pq_pkg::byte_t data_a_i,
  input  logic          we_b_i,
  input  logic [PW-1:0] addr_b_i,
  input  pq_pkg::byte_t data_b_i,
  input  logic [PW-1:0] raddr_i,
  output pq_pkg::byte_t rdata_o
);
  pq_pkg::byte_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          en_a, en_b, slot_en;
    pq_pkg::byte_t slot_d;

    always_comb begin
      en_a    = we_a_i && (addr_a_i == PW'(g));
      en_b    = we_b_i && (addr_b_i == PW'(g));
      slot_en = en_a || en_b;
      slot_d  = en_a ? data_a_i : data_b_i;
    end

    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= slot_d;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          wr_en_i,
  input  logic [15:0]   wr_data_i,
  input  logic [1:0]    wr_mask_i,
  input  logic          rd_en_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic [LW-1:0] level_o,
  output logic          fetch_req_o
);
  import pq_pkg::*;

  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] wr_ptr_p1, wr_ptr_adv, rd_ptr_adv;
  logic [LW-1:0] level, free_slots;
  logic [1:0]    nbytes, push_n;
  logic          push_ok, pop_ok;
  byte_t         first_byte;

  always_comb begin
    nbytes     = mask_bytes(wr_mask_i);
    free_slots = LW'(DEPTH) - level;
    push_ok    = wr_en_i && !flush_i && (nbytes != 2'd0) && (free_slots >= LW'(nbytes));
    pop_ok     = rd_en_i && !flush_i && (level != '0);
    push_n     = push_ok ? nbytes : 2'd0;
    first_byte = wr_mask_i[0] ? wr_data_i[7:0] : wr_data_i[15:8];
  end

  pq_ptr_adv #(.DEPTH(DEPTH)) u_wp_one (.ptr_i(wr_ptr_q), .inc_i(2'd1),            .ptr_o(wr_ptr_p1));
  pq_ptr_adv #(.DEPTH(DEPTH)) u_wp_adv (.ptr_i(wr_ptr_q), .inc_i(push_n),          .ptr_o(wr_ptr_adv));
  pq_ptr_adv #(.DEPTH(DEPTH)) u_rp_adv (.ptr_i(rd_ptr_q), .inc_i({1'b0, pop_ok}),  .ptr_o(rd_ptr_adv));

  always_comb begin
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      wr_ptr_d = wr_ptr_adv;
      rd_ptr_d = rd_ptr_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  pq_level #(.DEPTH(DEPTH)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .add_i   (push_n),
    .sub_i   (pop_ok),
    .level_o (level)
  );

  pq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .we_a_i   (push_ok),
    .addr_a_i (wr_ptr_q),
    .data_a_i (first_byte),
    .we_b_i   (push_ok && (wr_mask_i == 2'b11)),
    .addr_b_i (wr_ptr_p1),
    .data_b_i (wr_data_i[15:8]),
    .raddr_i  (rd_ptr_q),
    .rdata_o  (rd_data_o)
  );

  assign level_o     = level;
  assign rd_valid_o  = (level != '0);
  assign fetch_req_o = (free_slots >= LW'(2));
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int DEPTH = 6,
  localparam int LW = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic          wr_en_i,
  input logic [1:0]    wr_mask_i,
  input logic          rd_en_i,
  input logic [7:0]    rd_data_o,
  input logic          rd_valid_o,
  input logic [LW-1:0] level_o,
  input logic          fetch_req_o
);
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (level_o == '0) && !rd_valid_o);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_o) <= DEPTH);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !wr_en_i && !rd_en_i) |=> $stable(level_o) && (!rd_valid_o || $stable(rd_data_o)));

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !wr_en_i && rd_en_i && rd_valid_o) |=> (int'(level_o) + 1 == int'($past(level_o))));

  // R8
  push_pop_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && wr_en_i && wr_mask_i == 2'b11 && rd_en_i && rd_valid_o && int'(level_o) <= DEPTH - 2)
    |=> (int'(level_o) == int'($past(level_o)) + 1));

  // R5
  fetch_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level_o) == DEPTH) |-> !fetch_req_o);

  // R5
  fetch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> fetch_req_o);
endmodule

bind prefetch_queue prefetch_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .wr_en_i     (wr_en_i),
  .wr_mask_i   (wr_mask_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .level_o     (level_o),
  .fetch_req_o (fetch_req_o)
);

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [1:0]  wr_mask;
  logic        rd_en;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [2:0]  level;
  logic        fetch_req;

  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  byte unsigned model_q[$];

  prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .level_o(level),
    .fetch_req_o(fetch_req)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(level) == model_q.size(), "R9 level", int'(level), model_q.size());
    chk(rd_valid == (model_q.size() != 0), "R3 valid", int'(rd_valid), int'(model_q.size() != 0));
    chk(fetch_req == (model_q.size() <= 4), "R5 fetch_req", int'(fetch_req), int'(model_q.size() <= 4));
    if (model_q.size() != 0)
      chk(rd_data == model_q[0], "R2 head byte", int'(rd_data), int'(model_q[0]));
  endtask

  task automatic step(input bit fl, input bit we, input logic [15:0] d,
                      input logic [1:0] m, input bit re);
    int nb;
    bit acc;
    flush = fl; wr_en = we; wr_data = d; wr_mask = m; rd_en = re;
    @(posedge clk);
    if (fl) model_q.delete();
    else begin
      nb  = int'(m[0]) + int'(m[1]);
      acc = we && nb != 0 && (6 - model_q.size()) >= nb;
      if (re && model_q.size() != 0) void'(model_q.pop_front());
      if (acc) begin
        if (m[0]) model_q.push_back(d[7:0]);
        if (m[1]) model_q.push_back(d[15:8]);
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; wr_en = 0; wr_data = 0; wr_mask = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(level == 0 && !rd_valid && fetch_req, "R1 reset", int'({level, rd_valid, fetch_req}), 1);

    // R2 fill with words, R4 overflow attempts
    step(0, 1, 16'hA2A1, 2'b11, 0);
    step(0, 1, 16'hA4A3, 2'b11, 0);
    step(0, 1, 16'hA6A5, 2'b11, 0);
    chk(level == 6, "R4 full", int'(level), 6);
    step(0, 1, 16'hEEEE, 2'b11, 0);
    chk(level == 6 && rd_data == 8'hA1, "R4 rejected when full", int'(rd_data), 'hA1);
    step(0, 1, 16'hEEEE, 2'b11, 1);
    chk(level == 5 && rd_data == 8'hA2, "R4 pop does not free space same cycle", int'(level), 5);
    step(0, 1, 16'hEEEE, 2'b11, 0);
    chk(level == 5, "R4 word rejected at level 5", int'(level), 5);
    step(0, 1, 16'h00B1, 2'b01, 0);
    chk(level == 6, "R6 low byte fits last slot", int'(level), 6);
    // drain, then pop while empty R3
    for (int i = 0; i < 8; i++) step(0, 0, 16'h0, 2'b00, 1);
    chk(level == 0 && !rd_valid, "R3 empty pop ignored", int'(level), 0);

    // R6 masks
    step(0, 1, 16'hC2C1, 2'b10, 0);
    chk(rd_data == 8'hC2 && level == 1, "R6 high only", int'(rd_data), 'hC2);
    step(0, 1, 16'hD2D1, 2'b00, 0);
    chk(level == 1, "R6 empty mask", int'(level), 1);
    step(0, 1, 16'hD4D3, 2'b01, 0);
    step(0, 0, 16'h0, 2'b00, 1);
    chk(rd_data == 8'hD3, "R6 low only order", int'(rd_data), 'hD3);

    // R8 simultaneous write and pop, wrapping storage
    step(0, 1, 16'hE2E1, 2'b11, 1);
    chk(level == 2 && rd_data == 8'hE1, "R8 net plus one", int'(level), 2);
    step(0, 1, 16'hE4E3, 2'b11, 1);
    step(0, 1, 16'hE6E5, 2'b11, 1);
    chk(level == 4, "R8 chained", int'(level), 4);

    // R7 flush beats write and pop
    step(1, 1, 16'hF2F1, 2'b11, 1);
    chk(level == 0 && !rd_valid, "R7 flush", int'(level), 0);
    step(0, 1, 16'h9291, 2'b11, 0);
    chk(rd_data == 8'h91, "R7 refill after flush", int'(rd_data), 'h91);

    // mixed traffic
    for (int i = 0; i < 600; i++)
      step(($urandom % 23) == 0, $urandom % 2, 16'($urandom), 2'($urandom),
           ($urandom % 3) != 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule